// File: doc/BRIEF.md
# Power-mode sequencing controller

This block keeps track of which of four power modes a line-interface chipset is in. Software selects a mode by writing a control byte whose bit 4 ("link-down") and bit 3 ("power-down") together name the mode. From the mode the block drives three enables: one for the digital core, one for the isolation link across the barrier, and one for ring detection.

The two low-power modes have entry rules. Light sleep may only be entered when all three clock-configuration registers hold non-zero values. Deep sleep may only be entered once the second clock stage has been switched off, meaning its register reads zero. A request that breaks either rule is refused. The mode stays where it was and a sticky error flag is raised.

Once the block is in either low-power mode, software writes are ignored. The only way out is a low pulse on the external reset pin, and the block acts on it once the master clock is reported present. If the pulse arrives while the clock is stopped, it is remembered and acted on when the clock returns. The block then goes back to reset mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the system reset `rst_n`, `mode_o` is 2'b10 (reset mode), `core_en`=1, `link_en`=0, `ring_en`=0 and `err_o`=0.
- R2: In normal mode (`mode_o`=2'b00), `core_en` and `ring_en` are 1, and `link_en` is 1 only while all three clock-configuration inputs are non-zero.
- R3: In normal or reset mode, a write with `wr_en`=1 moves the block, on that clock edge, to the mode `{wr_data[4],wr_data[3]}`: 00 normal, 01 sleep, 10 reset, 11 deep sleep. All other data bits are ignored.
- R4: A sleep request (code 01) made while any clock-configuration input is zero leaves `mode_o` unchanged and sets `err_o`.
- R5: In sleep mode (`mode_o`=2'b01), `link_en`=1, `ring_en`=1 and `core_en`=0, whether or not `mclk_ok` is high.
- R6: In sleep or deep-sleep mode, writes do not change `mode_o`.
- R7: A low pulse on `pin_rst_n` that ends while `mclk_ok`=0 leaves the mode unchanged until `mclk_ok` goes high.
- R8: A completed low pulse on `pin_rst_n`, with `mclk_ok`=1, returns the block to reset mode from any mode and clears `err_o`.
- R9: A deep-sleep request (code 11) made while `cfg_stage2` is non-zero leaves `mode_o` unchanged and sets `err_o`. With `cfg_stage2` zero, it enters deep sleep.
- R10: In deep sleep (`mode_o`=2'b11), `core_en`, `link_en` and `ring_en` are all 0.
- R11: `err_o` stays set until a return to reset mode by R8 or a system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wr_en | input | 1 | Control-byte write strobe |
| wr_data | input | CTRL_W (8) | Control byte; bit 4 link-down, bit 3 power-down |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| mclk_ok | input | 1 | Master clock present |
| cfg_stage1_a | input | CFG_W (8) | First clock stage, divider setting |
| cfg_stage1_b | input | CFG_W (8) | First clock stage, multiplier setting |
| cfg_stage2 | input | CFG_W (8) | Second clock stage setting |
| mode_o | output | 2 | Current mode {link-down, power-down} |
| core_en | output | 1 | Core enable |
| link_en | output | 1 | Isolation-link enable |
| ring_en | output | 1 | Ring-detect enable |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
Each mode is reached by a legal write, and each low-power request is also tried against a configuration that must refuse it. A zero in the second stage tells the sleep check apart from the deep-sleep check. Writes that carry noise in the unused bits show that only bits 4 and 3 are decoded. Writes made during sleep and deep sleep separate ignored requests from real mode changes. Reset-pin pulses are given both with the master clock present and with it missing, which separates an immediate return from a deferred one. A pulse given in normal mode shows that the pin also clears the sticky flag.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_SLEEP  = 2'b01,
    PM_RESET  = 2'b10,
    PM_DEEP   = 2'b11
  } pm_mode_e;

  localparam int PM_PDN_BIT = 3;
  localparam int PM_PDL_BIT = 4;

  typedef struct packed {
    logic core;
    logic link;
    logic ring;
  } pm_en_t;

  function automatic pm_mode_e pm_decode(input logic pdl, input logic pdn);
    return pm_mode_e'({pdl, pdn});
  endfunction

  function automatic logic pm_is_low(input pm_mode_e m);
    return (m == PM_SLEEP) || (m == PM_DEEP);
  endfunction

  function automatic pm_en_t pm_enables(input pm_mode_e m, input logic clk_good);
    pm_en_t e;
    case (m)
      PM_RESET:  e = '{core: 1'b1, link: 1'b0,     ring: 1'b0};
      PM_NORMAL: e = '{core: 1'b1, link: clk_good, ring: 1'b1};
      PM_SLEEP:  e = '{core: 1'b0, link: 1'b1,     ring: 1'b1};
      default:   e = '{core: 1'b0, link: 1'b0,     ring: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_pin_tracker.sv
module pwr_pin_tracker #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_rst_n,
  input  logic mclk_ok,
  output logic pin_low,
  output logic pending,
  output logic rst_fire
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          armed_q;
  logic          pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SW-2:0], pin_rst_n};
  end

  assign pin_s    = sync_q[SW-1];
  assign rst_fire = armed_q & pin_s & mclk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (!pin_s)   armed_q <= 1'b1;
    else if (rst_fire) armed_q <= 1'b0;
  end

  assign pin_low = ~pin_s;
  assign pending = armed_q;
endmodule

// File: rtl/pwr_req_check.sv
module pwr_req_check
  import pwr_mode_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int CFG_W  = 8
) (
  input  pm_mode_e          mode,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [CFG_W-1:0]  cfg_a,
  input  logic [CFG_W-1:0]  cfg_b,
  input  logic [CFG_W-1:0]  cfg_c,
  output logic              cfg_ok_all,
  output logic              stage2_zero,
  output logic              req_take,
  output logic              req_reject,
  output pm_mode_e          req_mode
);
  function automatic logic all_nonzero(input logic [CFG_W-1:0] a,
                                       input logic [CFG_W-1:0] b,
                                       input logic [CFG_W-1:0] c);
    return (|a) & (|b) & (|c);
  endfunction

  logic wr_live;
  logic legal;

  assign cfg_ok_all  = all_nonzero(cfg_a, cfg_b, cfg_c);
  assign stage2_zero = ~(|cfg_c);
  assign req_mode    = pm_decode(wr_data[PM_PDL_BIT], wr_data[PM_PDN_BIT]);
  assign wr_live     = wr_en & ~hold & ~pm_is_low(mode);

  always_comb begin
    case (req_mode)
      PM_SLEEP: legal = cfg_ok_all;
      PM_DEEP:  legal = stage2_zero;
      default:  legal = 1'b1;
    endcase
  end

  assign req_take   = wr_live & legal;
  assign req_reject = wr_live & ~legal;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rst_fire,
  input  logic     req_take,
  input  logic     req_reject,
  input  pm_mode_e req_mode,
  input  logic     clk_good,
  output pm_mode_e mode,
  output logic     err,
  output pm_en_t   en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_RESET;
      err  <= 1'b0;
    end else if (rst_fire) begin
      mode <= PM_RESET;
      err  <= 1'b0;
    end else begin
      if (req_take)   mode <= req_mode;
      if (req_reject) err  <= 1'b1;
    end
  end

  assign en = pm_enables(mode, clk_good);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int CTRL_W      = 8,
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              pin_rst_n,
  input  logic              mclk_ok,
  input  logic [CFG_W-1:0]  cfg_stage1_a,
  input  logic [CFG_W-1:0]  cfg_stage1_b,
  input  logic [CFG_W-1:0]  cfg_stage2,
  output logic [1:0]        mode_o,
  output logic              core_en,
  output logic              link_en,
  output logic              ring_en,
  output logic              err_o
);
  logic     pin_low, pending, rst_fire;
  logic     cfg_ok_all, stage2_zero;
  logic     req_take, req_reject;
  pm_mode_e req_mode, mode;
  pm_en_t   en;
  logic     err;

  pwr_pin_tracker #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .mclk_ok(mclk_ok),
    .pin_low(pin_low), .pending(pending), .rst_fire(rst_fire)
  );

  pwr_req_check #(.CTRL_W(CTRL_W), .CFG_W(CFG_W)) u_req (
    .mode(mode), .hold(pin_low | pending), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_a(cfg_stage1_a), .cfg_b(cfg_stage1_b), .cfg_c(cfg_stage2),
    .cfg_ok_all(cfg_ok_all), .stage2_zero(stage2_zero),
    .req_take(req_take), .req_reject(req_reject), .req_mode(req_mode)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rst_fire(rst_fire), .req_take(req_take),
    .req_reject(req_reject), .req_mode(req_mode), .clk_good(cfg_ok_all),
    .mode(mode), .err(err), .en(en)
  );

  assign mode_o  = mode;
  assign core_en = en.core;
  assign link_en = en.link;
  assign ring_en = en.ring;
  assign err_o   = err;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       err_o,
  input logic       core_en,
  input logic       link_en,
  input logic       ring_en,
  input logic       rst_fire,
  input logic       cfg_ok_all,
  input logic       stage2_zero
);
  logic low_mode;
  assign low_mode = mode_o[0];

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (low_mode && !rst_fire) |=> $stable(mode_o));

  a_r4_sleep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01 && $past(mode_o) != 2'b01) |-> $past(cfg_ok_all));

  a_r9_deep_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11 && $past(mode_o) != 2'b11) |-> $past(stage2_zero));

  a_r10_deep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b11) |-> !(core_en || link_en || ring_en));

  a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> (mode_o == 2'b10 && !err_o));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !rst_fire) |=> err_o);
endmodule

bind pwr_mode_seq pwr_mode_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .err_o(err_o),
  .core_en(core_en), .link_en(link_en), .ring_en(ring_en),
  .rst_fire(rst_fire), .cfg_ok_all(cfg_ok_all), .stage2_zero(stage2_zero)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pin_rst_n = 1'b1;
  logic       mclk_ok = 1'b1;
  logic [7:0] cfg_a = 8'h00, cfg_b = 8'h00, cfg_c = 8'h00;
  logic [1:0] mode_o;
  logic       core_en, link_en, ring_en, err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic       core, link, ring, err;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pwr_mode_seq i_pwr_mode_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pin_rst_n(pin_rst_n), .mclk_ok(mclk_ok),
    .cfg_stage1_a(cfg_a), .cfg_stage1_b(cfg_b), .cfg_stage2(cfg_c),
    .mode_o(mode_o), .core_en(core_en), .link_en(link_en),
    .ring_en(ring_en), .err_o(err_o)
  );

  // expected enables per mode, restated from R1/R2/R5/R10
  task automatic expect_mode(input string tag, input logic [1:0] m, input logic e);
    exp_t x;
    x.tag = tag; x.mode = m; x.err = e;
    case (m)
      2'b10: begin x.core = 1; x.link = 0; x.ring = 0; end
      2'b00: begin x.core = 1; x.link = (cfg_a != 0 && cfg_b != 0 && cfg_c != 0); x.ring = 1; end
      2'b01: begin x.core = 0; x.link = 1; x.ring = 1; end
      default: begin x.core = 0; x.link = 0; x.ring = 0; end
    endcase
    @(posedge clk);
    q.push_back(x);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_pin();
    @(negedge clk); pin_rst_n = 1'b0;
    repeat (5) @(negedge clk);
    pin_rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (mode_o !== x.mode || core_en !== x.core || link_en !== x.link ||
            ring_en !== x.ring || err_o !== x.err) begin
          errors++;
          $display("FAIL %s: got mode=%b core=%b link=%b ring=%b err=%b, expected mode=%b core=%b link=%b ring=%b err=%b",
                   x.tag, mode_o, core_en, link_en, ring_en, err_o,
                   x.mode, x.core, x.link, x.ring, x.err);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_mode("R1 reset state", 2'b10, 0);
    wr(8'h00);
    expect_mode("R2 normal, clocks zero", 2'b00, 0);
    @(negedge clk); cfg_a = 8'h05; cfg_b = 8'h03; cfg_c = 8'h07;
    expect_mode("R2 normal, clocks valid", 2'b00, 0);
    wr(8'h10);
    expect_mode("R3 back to reset mode", 2'b10, 0);
    wr(8'hE7);
    expect_mode("R3 unused bits ignored", 2'b00, 0);
    @(negedge clk); cfg_c = 8'h00;
    wr(8'h08);
    expect_mode("R4 sleep refused", 2'b00, 1);
    @(negedge clk); cfg_c = 8'h07;
    wr(8'h08);
    expect_mode("R5 sleep entered, R11 err kept", 2'b01, 1);
    @(negedge clk); mclk_ok = 1'b0;
    expect_mode("R5 sleep without mclk", 2'b01, 1);
    wr(8'h00);
    expect_mode("R6 write ignored in sleep", 2'b01, 1);
    pulse_pin();
    expect_mode("R7 pulse pending without mclk", 2'b01, 1);
    @(negedge clk); mclk_ok = 1'b1;
    repeat (2) @(negedge clk);
    expect_mode("R8 return after mclk", 2'b10, 0);
    wr(8'h00);
    wr(8'h18);
    expect_mode("R9 deep refused, stage2 on", 2'b00, 1);
    @(negedge clk); cfg_c = 8'h00;
    wr(8'h18);
    expect_mode("R10 deep entered", 2'b11, 1);
    wr(8'h10);
    expect_mode("R6 write ignored in deep", 2'b11, 1);
    pulse_pin();
    expect_mode("R8 exit deep", 2'b10, 0);
    @(negedge clk); cfg_c = 8'h07;
    wr(8'h00);
    wr(8'h18);
    expect_mode("R11 err set in normal", 2'b00, 1);
    pulse_pin();
    expect_mode("R8 pulse from normal", 2'b10, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule